// File: doc/BRIEF.md
# Process-Selective Translation Flush Walker

This block sweeps a pair of translation lookaside arrays (one for instruction fetch, one for data) after a process identifier has been retired or reassigned. When a start strobe arrives, it captures the requested process identifier and reads every entry of both arrays in a fixed order through a combinational read port. For each entry it decides whether that entry belongs to the requested process. If it does, the block rebuilds the page's virtual address and presents it on a flush output. Downstream translation caches drop exactly those pages and keep everything else.

The walk runs one entry per clock while the flush output is free. It stops whenever a flush address is waiting and the receiver has not taken it. Entries marked global and entries marked invalid are skipped, so pages shared by every process survive. A one-cycle completion pulse ends each sweep. The sweep is driven by four named states, with these transitions:

- **IDLE**: waiting for a start strobe. On a strobe it takes transition LAUNCH into SCAN.
- **SCAN**: visits one entry per unstalled cycle. After the final entry it takes transition SWEPT into DRAIN.
- **DRAIN**: holds a pending flush address until it is accepted. Once nothing is pending or the address is taken, it takes transition SETTLE into DONE.
- **DONE**: raises the completion pulse and takes transition RETIRE back to IDLE.

Top module: `tlb_pid_sweeper`

## Requirements
- R1: While reset is asserted and after it is released, busy, done and flush-valid are low until a start strobe is accepted.
- R2: A start strobe seen in IDLE captures bits 7:0 of the request word as the process identifier; bits above 7 have no effect. Busy is high from the next cycle.
- R3: Entries are visited with the array number as the most significant part, then the way, then the index (index fastest). Array 0 is instruction and array 1 is data; there are 4 ways of 16 entries each. Flush addresses leave in that visiting order.
- R4: An entry is flushed exactly when its valid bit is 1, its global bit is 0, and its stored 8-bit process identifier equals the captured one. No other entry produces a flush.
- R5: The flush address is the entry's stored 19-bit virtual page number placed at bits 31:13, with bits 12:0 zero.
- R6: With the flush output always ready, a sweep keeps busy high for exactly 129 cycles: 128 entries plus one drain cycle.
- R7: While flush-valid is high and flush-ready is low, flush-valid stays high and the address stays unchanged on the next cycle.
- R8: Done is high for exactly one cycle. It rises in the cycle after the last flush address is accepted (or after the drain when none is pending). Busy is low in that cycle, and no flush is valid then.
- R9: A start strobe that arrives while busy or while done is high is ignored. The sweep in progress keeps its captured identifier, and no new sweep begins.
- R10: A sweep in which no entry matches produces no flush address and still completes with a done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only in IDLE |
| pid_i | input | 32 | Request word; bits 7:0 hold the process identifier |
| busy_o | output | 1 | High during SCAN and DRAIN |
| done_o | output | 1 | One-cycle completion pulse |
| tlb_rd_o | output | 1 | Read port active (SCAN) |
| tlb_arr_o | output | 1 | Array select for the read port (0 instruction, 1 data) |
| tlb_way_o | output | 2 | Way select for the read port |
| tlb_idx_o | output | 4 | Entry index for the read port |
| tlb_vpn_i | input | 19 | Stored virtual page number of the addressed entry |
| tlb_pid_i | input | 8 | Stored process identifier of the addressed entry |
| tlb_v_i | input | 1 | Valid bit of the addressed entry |
| tlb_g_i | input | 1 | Global bit of the addressed entry |
| flush_valid_o | output | 1 | Flush address valid |
| flush_ready_i | input | 1 | Receiver accepts the flush address |
| flush_addr_o | output | 32 | Page-aligned virtual address to invalidate |

## Verification
The checker watches every cycle for the local rules of the block:
- a held flush address stays stable while it is stalled;
- flush addresses are page-aligned;
- done lasts one cycle, never overlaps busy, and only follows a busy cycle;
- a flush is only valid during a sweep;
- a strobe in IDLE always launches a sweep.

Which entries get flushed, and in what order, can only be shown by the bench's scenarios. Its table model covers mixed valid, global and identifier patterns, random back-pressure, and a sweep with no matches. The bench also shows that a mid-sweep or done-cycle strobe with a different identifier does not alter the sequence, and that an unstalled sweep takes 129 busy cycles.

// File: rtl/pid_sweep_pkg.sv
package pid_sweep_pkg;

    typedef enum logic [1:0] {
        SW_IDLE  = 2'd0,
        SW_SCAN  = 2'd1,
        SW_DRAIN = 2'd2,
        SW_DONE  = 2'd3
    } sweep_state_t;

endpackage

// File: rtl/sweep_fsm.sv
module sweep_fsm
    import pid_sweep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stall_i,
    input  logic last_i,
    input  logic pending_i,
    input  logic ready_i,
    output logic busy_o,
    output logic done_o,
    output logic launch_o,
    output logic step_o,
    output logic scan_o
);

    sweep_state_t state_q;
    sweep_state_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SW_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: LAUNCH, SWEPT, SETTLE, RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_IDLE: begin
                if (start_i) begin
                    state_d = SW_SCAN;
                end
            end
            SW_SCAN: begin
                if (!stall_i && last_i) begin
                    state_d = SW_DRAIN;
                end
            end
            SW_DRAIN: begin
                if (!pending_i || ready_i) begin
                    state_d = SW_DONE;
                end
            end
            SW_DONE: begin
                state_d = SW_IDLE;
            end
            default: state_d = SW_IDLE;
        endcase
    end

    // Outputs decoded from the current state
    always_comb begin
        busy_o   = 1'b0;
        done_o   = 1'b0;
        launch_o = 1'b0;
        step_o   = 1'b0;
        scan_o   = 1'b0;
        unique case (state_q)
            SW_IDLE: begin
                launch_o = start_i;
            end
            SW_SCAN: begin
                busy_o = 1'b1;
                scan_o = 1'b1;
                step_o = !stall_i;
            end
            SW_DRAIN: begin
                busy_o = 1'b1;
            end
            SW_DONE: begin
                done_o = 1'b1;
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sweep_cursor.sv
module sweep_cursor #(
    parameter int ARRAYS = 2,
    parameter int WAYS   = 4,
    parameter int SETS   = 16,
    localparam int ARR_W   = $clog2(ARRAYS),
    localparam int WAY_W   = $clog2(WAYS),
    localparam int IDX_W   = $clog2(SETS),
    localparam int TOTAL   = ARRAYS * WAYS * SETS,
    localparam int ENTRY_W = ARR_W + WAY_W + IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    output logic [ARR_W-1:0] arr_o,
    output logic [WAY_W-1:0] way_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o
);

    logic [ENTRY_W-1:0] pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (clear_i) begin
            pos_q <= '0;
        end else if (step_i) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    // Index varies fastest, then way, then array.
    assign idx_o  = pos_q[IDX_W-1:0];
    assign way_o  = pos_q[IDX_W +: WAY_W];
    assign arr_o  = pos_q[IDX_W+WAY_W +: ARR_W];
    assign last_o = (pos_q == ENTRY_W'(TOTAL - 1));

endmodule

// File: rtl/entry_match.sv
module entry_match #(
    parameter int PID_W = 8
) (
    input  logic [PID_W-1:0] want_pid_i,
    input  logic [PID_W-1:0] ent_pid_i,
    input  logic             ent_v_i,
    input  logic             ent_g_i,
    output logic             hit_o
);

    always_comb begin
        hit_o = ent_v_i && !ent_g_i && (ent_pid_i == want_pid_i);
    end

endmodule

// File: rtl/flush_slot.sv
module flush_slot #(
    parameter int VPN_W      = 19,
    parameter int PAGE_SHIFT = 13,
    localparam int FLUSH_W   = VPN_W + PAGE_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_i,
    input  logic               hit_i,
    input  logic [VPN_W-1:0]   vpn_i,
    input  logic               ready_i,
    output logic               valid_o,
    output logic [FLUSH_W-1:0] addr_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            addr_o  <= '0;
        end else if (step_i) begin
            // A step only happens when the slot is empty or being drained.
            valid_o <= hit_i;
            if (hit_i) begin
                addr_o <= {vpn_i, {PAGE_SHIFT{1'b0}}};
            end
        end else if (valid_o && ready_i) begin
            valid_o <= 1'b0;
        end
    end

endmodule

// File: rtl/tlb_pid_sweeper.sv
module tlb_pid_sweeper #(
    parameter int ARRAYS     = 2,
    parameter int WAYS       = 4,
    parameter int SETS       = 16,
    parameter int PID_W      = 8,
    parameter int PID_IN_W   = 32,
    parameter int VPN_W      = 19,
    parameter int PAGE_SHIFT = 13,
    localparam int ARR_W     = $clog2(ARRAYS),
    localparam int WAY_W     = $clog2(WAYS),
    localparam int IDX_W     = $clog2(SETS),
    localparam int FLUSH_W   = VPN_W + PAGE_SHIFT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [PID_IN_W-1:0] pid_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                tlb_rd_o,
    output logic [ARR_W-1:0]    tlb_arr_o,
    output logic [WAY_W-1:0]    tlb_way_o,
    output logic [IDX_W-1:0]    tlb_idx_o,
    input  logic [VPN_W-1:0]    tlb_vpn_i,
    input  logic [PID_W-1:0]    tlb_pid_i,
    input  logic                tlb_v_i,
    input  logic                tlb_g_i,
    output logic                flush_valid_o,
    input  logic                flush_ready_i,
    output logic [FLUSH_W-1:0]  flush_addr_o
);

    logic             launch;
    logic             step;
    logic             scan;
    logic             last;
    logic             stall;
    logic             hit;
    logic [PID_W-1:0] want_pid_q;
    logic             pid_hi_unused;

    assign pid_hi_unused = ^pid_i[PID_IN_W-1:PID_W];
    assign stall         = flush_valid_o && !flush_ready_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            want_pid_q <= '0;
        end else if (launch) begin
            want_pid_q <= pid_i[PID_W-1:0];
        end
    end

    sweep_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .stall_i   (stall),
        .last_i    (last),
        .pending_i (flush_valid_o),
        .ready_i   (flush_ready_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .launch_o  (launch),
        .step_o    (step),
        .scan_o    (scan)
    );

    sweep_cursor #(
        .ARRAYS (ARRAYS),
        .WAYS   (WAYS),
        .SETS   (SETS)
    ) u_cursor (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (launch),
        .step_i  (step),
        .arr_o   (tlb_arr_o),
        .way_o   (tlb_way_o),
        .idx_o   (tlb_idx_o),
        .last_o  (last)
    );

    assign tlb_rd_o = scan;

    entry_match #(
        .PID_W (PID_W)
    ) u_match (
        .want_pid_i (want_pid_q),
        .ent_pid_i  (tlb_pid_i),
        .ent_v_i    (tlb_v_i),
        .ent_g_i    (tlb_g_i),
        .hit_o      (hit)
    );

    flush_slot #(
        .VPN_W      (VPN_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (step),
        .hit_i   (hit),
        .vpn_i   (tlb_vpn_i),
        .ready_i (flush_ready_i),
        .valid_o (flush_valid_o),
        .addr_o  (flush_addr_o)
    );

endmodule

// File: rtl/sweep_checker.sv
module sweep_checker #(
    parameter int FA_W  = 32,
    parameter int LOW_W = 13
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            busy_o,
    input logic            done_o,
    input logic            flush_valid_o,
    input logic            flush_ready_i,
    input logic [FA_W-1:0] flush_addr_o
);

    // R7: a stalled flush keeps its valid and address
    a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid_o && !flush_ready_i) |=> (flush_valid_o && $stable(flush_addr_o)));

    // R5: flush addresses are page aligned
    a_r5_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid_o |-> (flush_addr_o[LOW_W-1:0] == '0));

    // R8: done lasts a single cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: done and busy never overlap
    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o));

    // R8: done follows a busy cycle
    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(busy_o));

    // R3: flushes only appear during a sweep
    a_r3_flush_in_sweep: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid_o |-> busy_o);

    // R2: a strobe in idle launches a sweep
    a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !done_o) |=> busy_o);

endmodule

bind tlb_pid_sweeper sweep_checker #(
    .FA_W  (FLUSH_W),
    .LOW_W (PAGE_SHIFT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .flush_valid_o (flush_valid_o),
    .flush_ready_i (flush_ready_i),
    .flush_addr_o  (flush_addr_o)
);

// File: tb/tlb_pid_sweeper_test.sv
module tlb_pid_sweeper_test;

    localparam int CLK_PERIOD = 10;
    localparam int N_ENT      = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] pid_i = '0;
    logic        busy_o, done_o, tlb_rd_o;
    logic [0:0]  tlb_arr_o;
    logic [1:0]  tlb_way_o;
    logic [3:0]  tlb_idx_o;
    logic [18:0] tlb_vpn_i;
    logic [7:0]  tlb_pid_i;
    logic        tlb_v_i, tlb_g_i;
    logic        flush_valid_o;
    logic        flush_ready_i = 1'b0;
    logic [31:0] flush_addr_o;

    logic [18:0] m_vpn [N_ENT];
    logic [7:0]  m_pid [N_ENT];
    logic        m_v   [N_ENT];
    logic        m_g   [N_ENT];
    logic [31:0] exp_addr [N_ENT];
    int          exp_n;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Table model: combinational read, flat position = array, way, index
    assign tlb_vpn_i = m_vpn[{tlb_arr_o, tlb_way_o, tlb_idx_o}];
    assign tlb_pid_i = m_pid[{tlb_arr_o, tlb_way_o, tlb_idx_o}];
    assign tlb_v_i   = m_v[{tlb_arr_o, tlb_way_o, tlb_idx_o}];
    assign tlb_g_i   = m_g[{tlb_arr_o, tlb_way_o, tlb_idx_o}];

    tlb_pid_sweeper uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .pid_i         (pid_i),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .tlb_rd_o      (tlb_rd_o),
        .tlb_arr_o     (tlb_arr_o),
        .tlb_way_o     (tlb_way_o),
        .tlb_idx_o     (tlb_idx_o),
        .tlb_vpn_i     (tlb_vpn_i),
        .tlb_pid_i     (tlb_pid_i),
        .tlb_v_i       (tlb_v_i),
        .tlb_g_i       (tlb_g_i),
        .flush_valid_o (flush_valid_o),
        .flush_ready_i (flush_ready_i),
        .flush_addr_o  (flush_addr_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // R4/R5/R3: expected flush list from the selection rule, in visiting order
    function automatic void build_expected(input logic [7:0] want);
        exp_n = 0;
        for (int e = 0; e < N_ENT; e++) begin
            if (m_v[e] && !m_g[e] && (m_pid[e] == want)) begin
                exp_addr[exp_n] = {m_vpn[e], 13'd0};
                exp_n++;
            end
        end
    endfunction

    function automatic void fill_directed();
        for (int e = 0; e < N_ENT; e++) begin
            m_vpn[e] = 19'((e * 4099 + 7) & 19'h7ffff);
            m_pid[e] = (e % 4 == 3) ? 8'h5b : 8'h5a;
            m_v[e]   = (e % 4 != 1);
            m_g[e]   = (e % 4 == 2);
        end
    endfunction

    function automatic void fill_random();
        for (int e = 0; e < N_ENT; e++) begin
            m_vpn[e] = 19'($urandom);
            m_pid[e] = 8'h11 * 8'(1 + ($urandom % 4));
            m_v[e]   = ($urandom % 4) != 0;
            m_g[e]   = ($urandom % 5) == 0;
        end
    endfunction

    task automatic run_scan(input logic [31:0] pid_word, input int ready_pct,
                            input bit poke_busy, input bit poke_done, input bit check_time);
        int got = 0;
        int bcnt = 0;
        int guard = 0;
        bit stalled = 0;
        bit fin = 0;
        logic [31:0] held = '0;
        build_expected(pid_word[7:0]);
        @(negedge clk);
        start_i = 1'b1;
        pid_i   = pid_word;
        @(negedge clk);
        start_i = 1'b0;
        pid_i   = $urandom;
        #1;
        check(busy_o === 1'b1, "R2 busy after start", 32'(busy_o), 32'd1);
        while (!fin && guard < 5000) begin
            flush_ready_i = (($urandom % 100) < 32'(ready_pct));
            if (poke_busy && guard == 40) begin
                start_i = 1'b1;
                pid_i   = {24'hffffff, pid_word[7:0] ^ 8'h01};
            end else begin
                start_i = 1'b0;
            end
            #1;
            if (stalled) begin
                check(flush_valid_o === 1'b1 && flush_addr_o === held, "R7 stalled flush held",
                      flush_addr_o, held);
            end
            stalled = flush_valid_o && !flush_ready_i;
            held    = flush_addr_o;
            if (busy_o) bcnt++;
            if (flush_valid_o && flush_ready_i) begin
                if (got < exp_n) begin
                    check(flush_addr_o === exp_addr[got], "R3 R4 R5 flush address",
                          flush_addr_o, exp_addr[got]);
                end else begin
                    check(1'b0, "R4 extra flush", flush_addr_o, 32'd0);
                end
                got++;
            end
            if (done_o) begin
                fin = 1;
                check(busy_o === 1'b0 && flush_valid_o === 1'b0, "R8 done cycle quiet",
                      {30'd0, busy_o, flush_valid_o}, 32'd0);
            end
            guard++;
            if (!fin) @(negedge clk);
        end
        check(fin, "R8 done reached", 32'(fin), 32'd1);
        check(got == exp_n, "R4 R10 flush count", 32'(got), 32'(exp_n));
        if (check_time) check(bcnt == 129, "R6 busy cycles", 32'(bcnt), 32'd129);
        // R9: strobe in the done cycle must not launch a sweep
        start_i = poke_done;
        pid_i   = pid_word;
        @(negedge clk);
        start_i = 1'b0;
        #1;
        check(done_o === 1'b0 && busy_o === 1'b0, "R8 R9 after done",
              {30'd0, done_o, busy_o}, 32'd0);
        flush_ready_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        fill_directed();
        // R1: quiet during and after reset
        repeat (3) @(negedge clk);
        check(busy_o === 1'b0 && done_o === 1'b0 && flush_valid_o === 1'b0, "R1 in reset",
              {29'd0, busy_o, done_o, flush_valid_o}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(busy_o === 1'b0 && done_o === 1'b0 && flush_valid_o === 1'b0, "R1 after reset",
              {29'd0, busy_o, done_o, flush_valid_o}, 32'd0);

        // Directed: valid/global/pid patterns, no back-pressure, timing (R4 R5 R6)
        run_scan(32'h0000_005a, 100, 1'b0, 1'b0, 1'b1);
        // R2: upper request bits ignored
        run_scan(32'hdead_be5a, 100, 1'b0, 1'b1, 1'b1);
        // R10: no match
        run_scan(32'h0000_0077, 100, 1'b0, 1'b0, 1'b1);
        // R7: back-pressure on the directed table
        run_scan(32'h0000_005b, 40, 1'b1, 1'b0, 1'b0);

        // Random tables, random back-pressure, mid-sweep strobes (R9)
        for (int t = 0; t < 8; t++) begin
            fill_random();
            run_scan({$urandom % 32'h00ff_ffff, 8'h11 * 8'(1 + (t % 4))}, 30 + 10 * t,
                     (t % 2) == 0, (t % 3) == 0, 1'b0);
        end

        // R10: all entries global for the requested id
        for (int e = 0; e < N_ENT; e++) begin
            m_pid[e] = 8'h33;
            m_v[e]   = 1'b1;
            m_g[e]   = 1'b1;
        end
        run_scan(32'h0000_0033, 100, 1'b0, 1'b0, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule